// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles. It returns a quotient (the LO word) and a remainder (the HI word). One wide shift register carries the partial remainder in its upper half and, in its lower half, the dividend bits that remain to be consumed. The register shifts left on every iteration, and each new quotient bit enters at its least significant bit. Only one subtractor and one divisor register are needed.

A caller presents the operands and a signed-mode flag, then pulses `start` while the block is idle. `busy` stays high while the division runs. `done` pulses for one cycle when the results are placed on the outputs. The results hold until the next division completes.

In signed mode the block divides the operand magnitudes and then corrects the signs. The block flags neither overflow nor a zero divisor. Both cases still yield a fixed, repeatable result.

Top module: `seq_divider`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `quo` and `rem` are 0.
- R2: In unsigned mode (`signed_mode`=0), `quo` is floor(dividend/divisor) and `rem` is dividend mod divisor. For example, 7 / 2 gives 3 remainder 1.
- R3: In signed mode (`signed_mode`=1), the operands are two's complement. The quotient is truncated toward zero and negated when the operand signs differ. The remainder carries the dividend's sign. For example, -7 / 2 gives -3 remainder -1, and -7 / -2 gives 3 remainder -1.
- R4: A `start` seen high while idle sets `busy` at that edge. `done` is high for exactly one cycle, 33 clock edges after the accepting edge. `busy` falls at the same edge where `done` rises, and the two are never high together.
- R5: A `start` pulse while `busy` is high has no effect. The running division finishes on its own schedule with its own operands.
- R6: An unsigned divisor with bit 31 set gives the correct quotient and remainder. For example, 0xFFFFFFFF / 0x80000000 gives 1 remainder 0x7FFFFFFF.
- R7: With a zero divisor in unsigned mode, `quo` is 0xFFFFFFFF and `rem` equals the dividend. In signed mode the R3 sign rules apply to that same magnitude result: `quo` is 1 for a negative dividend and 0xFFFFFFFF otherwise, and `rem` equals the dividend.
- R8: `quo` and `rem` change only at the edge where `done` rises.
- R9: For any nonzero divisor, quotient × divisor + remainder equals the dividend, and |remainder| < |divisor|. Signed mode excludes the single wrapping case -2^31 / -1, whose quotient is 0x80000000 with remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a division; honoured only while idle |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled at the accepting edge |
| divisor | input | 32 | Divisor, sampled at the accepting edge |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| quo | output | 32 | Quotient (LO) |
| rem | output | 32 | Remainder (HI) |

## Verification
The handshake assertions assume that `start` is a clean synchronous level and that the operands need only be valid at the edge where `start` is accepted. The bench therefore changes inputs only on falling clock edges. It holds `start` for a single cycle and lets the operand lines change while a division is running. It also raises `start` mid-division, with operands that would give a different answer, to confirm that an accepting edge never happens while `busy` is high. Zero divisors and the most negative dividend are applied on purpose, because the assertions do not depend on the operand values.

// File: rtl/div_pkg.sv
// Shared types for the sequential divider.
// Assumes nothing beyond a synthesizable two-bit state encoding.
package div_pkg;
    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_RUN  = 2'd1,
        DS_FIX  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
// Converts raw operands to magnitudes and works out the result sign flags.
// Assumes two's complement inputs when sgn is set; purely combinational.
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_q,
    output logic         neg_r
);
    logic a_neg, b_neg;

    // Purpose: take absolute values and derive the quotient and remainder signs.
    always_comb begin
        a_neg = sgn & a[W-1];
        b_neg = sgn & b[W-1];
        mag_a = a_neg ? (~a + 1'b1) : a;
        mag_b = b_neg ? (~b + 1'b1) : b;
        neg_q = a_neg ^ b_neg;
        neg_r = a_neg;
    end
endmodule

// File: rtl/div_shift_core.sv
// Restoring shift-subtract engine on one 2W-bit register plus one carry bit.
// The register is loaded already shifted left by one. Every step compares the
// upper half (with the carry bit) against the divisor using a W+1 bit subtract,
// keeps or restores it, then shifts left and inserts the quotient bit.
// Assumes the caller issues exactly W steps after a load.
module div_shift_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag
);
    localparam int AW = 2 * W;

    logic [W-1:0]  dvsr_q;
    logic [AW-1:0] acc_q;
    logic          ext_q;
    logic [W:0]    upper;
    logic [W:0]    diff;
    logic          below;

    // Purpose: trial-subtract the divisor from the extended upper half.
    always_comb begin
        upper = {ext_q, acc_q[AW-1:W]};
        diff  = upper - {1'b0, dvsr_q};
        below = diff[W];
    end

    // Purpose: load the pre-shifted dividend, or run one restore-and-shift step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvsr_q <= '0;
            acc_q  <= '0;
            ext_q  <= 1'b0;
        end else if (load) begin
            dvsr_q <= mag_b;
            acc_q  <= {{(W-1){1'b0}}, mag_a, 1'b0};
            ext_q  <= 1'b0;
        end else if (step) begin
            if (below) begin
                {ext_q, acc_q} <= {upper[W-1:0], acc_q[W-1:0], 1'b0};
            end else begin
                {ext_q, acc_q} <= {diff[W-1:0], acc_q[W-1:0], 1'b1};
            end
        end
    end

    // Purpose: expose the quotient and undo the last shift on the remainder.
    always_comb begin
        quo_mag = acc_q[W-1:0];
        rem_mag = {ext_q, acc_q[AW-1:W+1]};
    end
endmodule

// File: rtl/div_sign_fix.sv
// Applies the sign flags to the magnitude results.
// Assumes magnitudes from the core and the flags latched at start; combinational.
module div_sign_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         neg_q,
    input  logic         neg_r,
    output logic [W-1:0] quo_s,
    output logic [W-1:0] rem_s
);
    // Purpose: negate the quotient and remainder where their flags ask for it.
    always_comb begin
        quo_s = neg_q ? (~quo_mag + 1'b1) : quo_mag;
        rem_s = neg_r ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/seq_divider.sv
// Top level of the sequential divider: start/busy/done control and result registers.
// One load cycle, W iteration cycles and one sign-fix cycle, so done arrives W+1
// edges after the accepting edge. Assumes start is synchronous to clk.
module seq_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    import div_pkg::*;

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e    state_q;
    logic [CW-1:0] iter_q;
    logic          neg_q_q, neg_r_q;
    logic [W-1:0]  mag_a, mag_b, quo_mag, rem_mag, quo_s, rem_s;
    logic          neg_q_c, neg_r_c;
    logic          load, step;

    div_operand_prep #(.W(W)) u_prep (
        .a(dividend), .b(divisor), .sgn(signed_mode),
        .mag_a(mag_a), .mag_b(mag_b), .neg_q(neg_q_c), .neg_r(neg_r_c)
    );

    div_shift_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .mag_a(mag_a), .mag_b(mag_b), .quo_mag(quo_mag), .rem_mag(rem_mag)
    );

    div_sign_fix #(.W(W)) u_fix (
        .quo_mag(quo_mag), .rem_mag(rem_mag), .neg_q(neg_q_q), .neg_r(neg_r_q),
        .quo_s(quo_s), .rem_s(rem_s)
    );

    // Purpose: decode core controls from the state.
    always_comb begin
        load = (state_q == DS_IDLE) && start;
        step = (state_q == DS_RUN);
    end

    // Purpose: sequence load, iterate and fix; register results and handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
            iter_q  <= '0;
            neg_q_q <= 1'b0;
            neg_r_q <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            quo     <= '0;
            rem     <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                DS_IDLE: begin
                    if (start) begin
                        state_q <= DS_RUN;
                        iter_q  <= '0;
                        neg_q_q <= neg_q_c;
                        neg_r_q <= neg_r_c;
                        busy    <= 1'b1;
                    end
                end
                DS_RUN: begin
                    iter_q <= iter_q + 1'b1;
                    if (iter_q == LAST) begin
                        state_q <= DS_FIX;
                    end
                end
                DS_FIX: begin
                    quo     <= quo_s;
                    rem     <= rem_s;
                    done    <= 1'b1;
                    busy    <= 1'b0;
                    state_q <= DS_IDLE;
                end
                default: state_q <= DS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/div_checker.sv
// Handshake and output-hold properties for seq_divider, attached by bind.
// Assumes synchronous reset and inputs that change away from the rising edge.
module div_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quo,
    input logic [W-1:0] rem
);
    // R4
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quo) && $stable(rem)));

    // R5
    busy_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !$rose(busy)) |=> (busy || done));
endmodule

bind seq_divider div_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .quo(quo), .rem(rem)
);

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done;
    logic [31:0] quo, rem;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit armed = 1'b0;

    // reference model state
    bit          m_busy = 1'b0;
    bit          m_done = 1'b0;
    int          m_cnt = 0;
    logic [31:0] m_q = '0, m_r = '0, e_q = '0, e_r = '0;
    string       m_tag = "R1";

    seq_divider #(.W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quo(quo), .rem(rem)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void expect_div(input logic [31:0] a, input logic [31:0] b,
                                       input bit s, output logic [31:0] q,
                                       output logic [31:0] r);
        longint sa, sb, lq, lr;
        if (b == 32'd0) begin
            q = (s && a[31]) ? 32'd1 : 32'hFFFF_FFFF;
            r = a;
        end else if (!s) begin
            q = a / b;
            r = a % b;
        end else begin
            sa = longint'(signed'(a));
            sb = longint'(signed'(b));
            lq = sa / sb;
            lr = sa % sb;
            q = lq[31:0];
            r = lr[31:0];
        end
    endfunction

    // Reference model: accepts start when idle, finishes 33 edges later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0; m_q <= '0; m_r <= '0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy && start) begin
                expect_div(dividend, divisor, signed_mode, e_q, e_r);
                m_busy <= 1'b1;
                m_cnt  <= 0;
            end else if (m_busy) begin
                if (m_cnt == 32) begin
                    m_busy <= 1'b0; m_done <= 1'b1; m_q <= e_q; m_r <= e_r;
                end else begin
                    m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    // Compare on every clock, away from the rising edge; watchdog.
    always @(negedge clk) begin
        cycles++;
        if (armed) begin
            chk("R4", "busy", {31'd0, busy}, {31'd0, m_busy});
            chk("R4", "done", {31'd0, done}, {31'd0, m_done});
            chk(m_tag, "quo", quo, m_q);   // R8 hold between completions
            chk(m_tag, "rem", rem, m_r);
        end
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_div(input logic [31:0] a, input logic [31:0] b,
                           input bit s, input string tag, input bit poke);
        logic [31:0] gq, gr;
        longint lhs, rhs;
        @(negedge clk);
        m_tag = tag;
        dividend = a; divisor = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dividend = ~a; divisor = b ^ 32'h5; signed_mode = ~s;
        if (poke) begin
            // R5: start while busy with different operands
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        gq = quo; gr = rem;
        // R9 identity and remainder bound
        if (b != 0 && !(s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) begin
            if (!s) begin
                lhs = longint'({32'd0, gq}) * longint'({32'd0, b}) + longint'({32'd0, gr});
                rhs = longint'({32'd0, a});
                checks++;
                if (lhs != rhs || gr >= b) begin
                    errors++;
                    $display("FAIL R9 unsigned identity actual=%0d expected=%0d", lhs, rhs);
                end
            end else begin
                lhs = longint'(signed'(gq)) * longint'(signed'(b)) + longint'(signed'(gr));
                rhs = longint'(signed'(a));
                checks++;
                if (lhs != rhs) begin
                    errors++;
                    $display("FAIL R9 signed identity actual=%0d expected=%0d", lhs, rhs);
                end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", {31'd0, busy}, 32'd0);
        chk("R1", "done", {31'd0, done}, 32'd0);
        chk("R1", "quo", quo, 32'd0);
        chk("R1", "rem", rem, 32'd0);
        armed = 1'b1;

        run_div(32'd7, 32'd2, 1'b0, "R2", 1'b0);
        chk("R2", "7/2 quo", quo, 32'd3);
        chk("R2", "7/2 rem", rem, 32'd1);
        run_div(32'd100, 32'd7, 1'b0, "R2", 1'b0);
        run_div(32'd3, 32'd9, 1'b0, "R2", 1'b0);

        run_div(-32'sd7, 32'd2, 1'b1, "R3", 1'b0);
        chk("R3", "-7/2 quo", quo, -32'sd3);
        chk("R3", "-7/2 rem", rem, -32'sd1);
        run_div(-32'sd7, -32'sd2, 1'b1, "R3", 1'b0);
        chk("R3", "-7/-2 quo", quo, 32'd3);
        chk("R3", "-7/-2 rem", rem, -32'sd1);
        run_div(32'd7, -32'sd2, 1'b1, "R3", 1'b0);
        run_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R3", 1'b0);
        chk("R3", "min/-1 quo", quo, 32'h8000_0000);

        run_div(32'hFFFF_FFFF, 32'h8000_0000, 1'b0, "R6", 1'b0);
        chk("R6", "top-bit quo", quo, 32'd1);
        chk("R6", "top-bit rem", rem, 32'h7FFF_FFFF);
        run_div(32'hC000_0001, 32'hA000_0000, 1'b0, "R6", 1'b0);

        run_div(32'h1234_5678, 32'd0, 1'b0, "R7", 1'b0);
        chk("R7", "u/0 quo", quo, 32'hFFFF_FFFF);
        chk("R7", "u/0 rem", rem, 32'h1234_5678);
        run_div(-32'sd9, 32'd0, 1'b1, "R7", 1'b0);
        chk("R7", "s/0 quo", quo, 32'd1);
        chk("R7", "s/0 rem", rem, -32'sd9);

        run_div(32'd1000, 32'd3, 1'b0, "R5", 1'b1);
        chk("R5", "busy start ignored quo", quo, 32'd333);
        chk("R5", "busy start ignored rem", rem, 32'd1);

        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 3 == 0) rb = rb >> (i % 29);
            if (rb == 0) rb = 32'd5;
            run_div(ra, rb, 1'(i % 2), "R9", 1'(i % 17 == 0));
        end

        armed = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule